// File: doc/BRIEF.md
# Exception Entry and Vector Sequencer

This block turns pending exception requests into the state changes a 32-bit processor makes when it takes an exception. Each cycle it samples seven request lines, the current status word and the current program counter. It picks the most urgent request that is not masked. In the next cycle it issues, all at once, these outputs:

- a new status word;
- a write of the old status word into the saved-status register of the target mode;
- a write of the return address into that mode's link register;
- a program counter load with the vector address.

The vector address is a fixed offset per exception kind. That offset is added to a base of zero, or to a high base when the high-vector input is set.

The block also handles the return path. A return request with no exception pending loads the status word from the saved copy and the program counter from the link value that the register file presents. The register file, the fetch unit and the status register themselves sit outside this block. They act on the one-cycle strobes it produces. The cycle right after any strobe is a settling cycle: all inputs are ignored in it, so the surrounding logic can commit the new status word before the next decision is made.

Top module: `exc_vec_unit`

## Requirements
- R1: An entry loads the program counter with base plus an offset that depends on the exception kind: reset 0x00, undefined instruction 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C. Offset 0x14 is never produced.
- R2: The base is 0x00000000 when `hiVecEn` is 0 and 0xFFFF0000 when it is 1.
- R3: When several unmasked requests are pending, exactly one is taken. The order of precedence is reset, data abort, FIQ, IRQ, prefetch abort, undefined instruction, software interrupt.
- R4: A request on `reqIrq` is ignored while bit 7 of `curPsr` is 1. A request on `reqFiq` is ignored while bit 6 of `curPsr` is 1.
- R5: The target mode (bits 4:0) is 0x13 for reset and software interrupt, 0x1B for undefined instruction, 0x17 for both aborts, 0x12 for IRQ and 0x11 for FIQ.
- R6: On entry, `psrNew` equals `curPsr` with these changes: bits 4:0 set to the target mode, bit 5 cleared, bit 7 set, and bit 6 set for reset and FIQ. For all other kinds bit 6 keeps its value. All other bits keep their values.
- R7: On entry, `spsrWrEn` is 1, `spsrVal` equals the sampled `curPsr`, and `spsrMode` equals the target mode.
- R8: On entry, `lrWrEn` is 1 and `lrMode` is the target mode. `lrVal` is `curPc`+8 (modulo 2^32) for data abort and `curPc`+4 for every other kind.
- R9: With `retReq` set and no unmasked request pending, `psrNew` equals `savedPsr` and `pcNew` equals `retLink`, with `psrWrEn` and `pcLoad` at 1 and `spsrWrEn` and `lrWrEn` at 0. An unmasked request takes precedence over a return.
- R10: Inputs sampled at one rising edge produce their strobes for exactly the following cycle. In the cycle that follows a strobe, all requests are ignored and no strobe is produced.
- R11: While `rstN` is low, all write strobes and the load strobe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| curPsr | input | 32 | Current status word |
| curPc | input | 32 | Current program counter |
| savedPsr | input | 32 | Saved status word of the current mode, used on return |
| retLink | input | 32 | Return address from the link register, used on return |
| hiVecEn | input | 1 | Select high vector base |
| reqReset | input | 1 | Reset exception request |
| reqUndef | input | 1 | Undefined instruction request |
| reqSwi | input | 1 | Software interrupt request |
| reqPabt | input | 1 | Prefetch abort request |
| reqDabt | input | 1 | Data abort request |
| reqIrq | input | 1 | Normal interrupt request |
| reqFiq | input | 1 | Fast interrupt request |
| retReq | input | 1 | Exception return request |
| psrWrEn | output | 1 | Write `psrNew` into the status word |
| psrNew | output | 32 | New status word |
| spsrWrEn | output | 1 | Write saved-status register |
| spsrMode | output | 5 | Mode whose saved-status register is written |
| spsrVal | output | 32 | Value written to saved status |
| lrWrEn | output | 1 | Write link register |
| lrMode | output | 5 | Mode whose link register is written |
| lrVal | output | 32 | Return address written |
| pcLoad | output | 1 | Load program counter |
| pcNew | output | 32 | Program counter value to load |

## Verification
Single requests of each kind separate the seven vector offsets, target modes and link adjustments. With all lines raised at once, and with reset removed, the priority order is exposed. Asserting IRQ and FIQ with their mask bits set, both alone and alongside a lower request, shows that masking removes a request from arbitration rather than blocking lower ones. Random mixes of requests, status words, program counters, vector base selection and return requests cover the interaction of return with pending requests. A request held in the settling cycle shows that it is ignored there.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

  localparam int unsigned NUM_KIND = 7;
  localparam int unsigned KIND_W   = 3;
  localparam int unsigned MODE_W   = 5;

  // Index order is arbitration order: lower index wins.
  typedef enum logic [KIND_W-1:0] {
    KIND_RESET = 3'd0,
    KIND_DABT  = 3'd1,
    KIND_FIQ   = 3'd2,
    KIND_IRQ   = 3'd3,
    KIND_PABT  = 3'd4,
    KIND_UNDEF = 3'd5,
    KIND_SWI   = 3'd6
  } excKind_e;

  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;

  localparam int unsigned BIT_T = 5;
  localparam int unsigned BIT_F = 6;
  localparam int unsigned BIT_I = 7;

  // Strobes from control to datapath.
  typedef struct packed {
    logic     doEntry;
    logic     doReturn;
    excKind_e kind;
  } seqStrobe_t;

  function automatic logic [4:0] vecOffset(excKind_e k);
    case (k)
      KIND_RESET: vecOffset = 5'h00;
      KIND_UNDEF: vecOffset = 5'h04;
      KIND_SWI:   vecOffset = 5'h08;
      KIND_PABT:  vecOffset = 5'h0C;
      KIND_DABT:  vecOffset = 5'h10;
      KIND_IRQ:   vecOffset = 5'h18;
      default:    vecOffset = 5'h1C;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] targetMode(excKind_e k);
    case (k)
      KIND_RESET, KIND_SWI:  targetMode = MODE_SVC;
      KIND_UNDEF:            targetMode = MODE_UND;
      KIND_PABT, KIND_DABT:  targetMode = MODE_ABT;
      KIND_IRQ:              targetMode = MODE_IRQ;
      default:               targetMode = MODE_FIQ;
    endcase
  endfunction

  function automatic logic masksFast(excKind_e k);
    masksFast = (k == KIND_RESET) || (k == KIND_FIQ);
  endfunction

  function automatic logic [3:0] linkAdjust(excKind_e k);
    linkAdjust = (k == KIND_DABT) ? 4'd8 : 4'd4;
  endfunction

endpackage

// File: rtl/exc_vec_ctrl.sv
module exc_vec_ctrl
  import exc_vec_pkg::*;
#(
  parameter int unsigned KINDS = NUM_KIND
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [KINDS-1:0] reqVec,
  input  logic             maskIrq,
  input  logic             maskFiq,
  input  logic             retReq,
  output seqStrobe_t       strobe
);

  logic [KINDS-1:0] effReq;
  logic             holdOff;
  logic             anyReq;
  excKind_e         pickKind;

  generate
    for (genvar g = 0; g < KINDS; g++) begin : g_mask
      if (g == int'(KIND_IRQ)) begin : g_irq
        assign effReq[g] = reqVec[g] & ~maskIrq;
      end else if (g == int'(KIND_FIQ)) begin : g_fiq
        assign effReq[g] = reqVec[g] & ~maskFiq;
      end else begin : g_plain
        assign effReq[g] = reqVec[g];
      end
    end
  endgenerate

  assign anyReq = |effReq;

  always_comb begin
    pickKind = KIND_SWI;
    for (int i = KINDS - 1; i >= 0; i--) begin
      if (effReq[i]) pickKind = excKind_e'(KIND_W'(i));
    end
  end

  always_comb begin
    strobe.doEntry  = !holdOff && anyReq;
    strobe.doReturn = !holdOff && !anyReq && retReq;
    strobe.kind     = pickKind;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdOff <= 1'b0;
    else       holdOff <= strobe.doEntry || strobe.doReturn;
  end

endmodule

// File: rtl/exc_vec_dp.sv
module exc_vec_dp
  import exc_vec_pkg::*;
#(
  parameter int unsigned      DATA_W  = 32,
  parameter logic [DATA_W-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] curPsr,
  input  logic [DATA_W-1:0] curPc,
  input  logic [DATA_W-1:0] savedPsr,
  input  logic [DATA_W-1:0] retLink,
  input  logic              hiVecEn,
  output logic              psrWrEn,
  output logic [DATA_W-1:0] psrNew,
  output logic              spsrWrEn,
  output logic [MODE_W-1:0] spsrMode,
  output logic [DATA_W-1:0] spsrVal,
  output logic              lrWrEn,
  output logic [MODE_W-1:0] lrMode,
  output logic [DATA_W-1:0] lrVal,
  output logic              pcLoad,
  output logic [DATA_W-1:0] pcNew
);

  logic [DATA_W-1:0] vecBase;
  logic [DATA_W-1:0] entryPsr;
  logic [MODE_W-1:0] entryMode;

  assign vecBase   = hiVecEn ? HI_BASE : '0;
  assign entryMode = targetMode(strobe.kind);

  always_comb begin
    entryPsr               = curPsr;
    entryPsr[MODE_W-1:0]   = entryMode;
    entryPsr[BIT_T]        = 1'b0;
    entryPsr[BIT_I]        = 1'b1;
    entryPsr[BIT_F]        = curPsr[BIT_F] | masksFast(strobe.kind);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psrWrEn  <= 1'b0;
      psrNew   <= '0;
      spsrWrEn <= 1'b0;
      spsrMode <= '0;
      spsrVal  <= '0;
      lrWrEn   <= 1'b0;
      lrMode   <= '0;
      lrVal    <= '0;
      pcLoad   <= 1'b0;
      pcNew    <= '0;
    end else begin
      psrWrEn  <= strobe.doEntry || strobe.doReturn;
      pcLoad   <= strobe.doEntry || strobe.doReturn;
      spsrWrEn <= strobe.doEntry;
      lrWrEn   <= strobe.doEntry;
      if (strobe.doEntry) begin
        psrNew   <= entryPsr;
        spsrVal  <= curPsr;
        spsrMode <= entryMode;
        lrMode   <= entryMode;
        lrVal    <= curPc + DATA_W'(linkAdjust(strobe.kind));
        pcNew    <= vecBase | DATA_W'(vecOffset(strobe.kind));
      end else if (strobe.doReturn) begin
        psrNew   <= savedPsr;
        pcNew    <= retLink;
      end
    end
  end

endmodule

// File: rtl/exc_vec_unit.sv
module exc_vec_unit
  import exc_vec_pkg::*;
#(
  parameter int unsigned      DATA_W  = 32,
  parameter logic [DATA_W-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] curPsr,
  input  logic [DATA_W-1:0] curPc,
  input  logic [DATA_W-1:0] savedPsr,
  input  logic [DATA_W-1:0] retLink,
  input  logic              hiVecEn,
  input  logic              reqReset,
  input  logic              reqUndef,
  input  logic              reqSwi,
  input  logic              reqPabt,
  input  logic              reqDabt,
  input  logic              reqIrq,
  input  logic              reqFiq,
  input  logic              retReq,
  output logic              psrWrEn,
  output logic [DATA_W-1:0] psrNew,
  output logic              spsrWrEn,
  output logic [4:0]        spsrMode,
  output logic [DATA_W-1:0] spsrVal,
  output logic              lrWrEn,
  output logic [4:0]        lrMode,
  output logic [DATA_W-1:0] lrVal,
  output logic              pcLoad,
  output logic [DATA_W-1:0] pcNew
);

  logic [NUM_KIND-1:0] reqVec;
  seqStrobe_t          strobe;

  always_comb begin
    reqVec             = '0;
    reqVec[KIND_RESET] = reqReset;
    reqVec[KIND_DABT]  = reqDabt;
    reqVec[KIND_FIQ]   = reqFiq;
    reqVec[KIND_IRQ]   = reqIrq;
    reqVec[KIND_PABT]  = reqPabt;
    reqVec[KIND_UNDEF] = reqUndef;
    reqVec[KIND_SWI]   = reqSwi;
  end

  exc_vec_ctrl #(.KINDS(NUM_KIND)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqVec  (reqVec),
    .maskIrq (curPsr[BIT_I]),
    .maskFiq (curPsr[BIT_F]),
    .retReq  (retReq),
    .strobe  (strobe)
  );

  exc_vec_dp #(.DATA_W(DATA_W), .HI_BASE(HI_BASE)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .curPsr   (curPsr),
    .curPc    (curPc),
    .savedPsr (savedPsr),
    .retLink  (retLink),
    .hiVecEn  (hiVecEn),
    .psrWrEn  (psrWrEn),
    .psrNew   (psrNew),
    .spsrWrEn (spsrWrEn),
    .spsrMode (spsrMode),
    .spsrVal  (spsrVal),
    .lrWrEn   (lrWrEn),
    .lrMode   (lrMode),
    .lrVal    (lrVal),
    .pcLoad   (pcLoad),
    .pcNew    (pcNew)
  );

endmodule

// File: rtl/exc_vec_checker.sv
module exc_vec_checker #(
  parameter int unsigned      DATA_W  = 32,
  parameter logic [DATA_W-1:0] HI_BASE = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] curPsr,
  input logic [DATA_W-1:0] curPc,
  input logic [DATA_W-1:0] savedPsr,
  input logic [DATA_W-1:0] retLink,
  input logic              hiVecEn,
  input logic              retReq,
  input logic              psrWrEn,
  input logic [DATA_W-1:0] psrNew,
  input logic              spsrWrEn,
  input logic [4:0]        spsrMode,
  input logic [DATA_W-1:0] spsrVal,
  input logic              lrWrEn,
  input logic [4:0]        lrMode,
  input logic              pcLoad,
  input logic [DATA_W-1:0] pcNew
);

  localparam logic [DATA_W-1:0] OFFS_MASK = DATA_W'(32'h1C);

  // R1: vectors are word aligned and never the reserved slot
  assert_vec_slot_R1: assert property (@(posedge clk) disable iff (!rstN)
    spsrWrEn |-> (pcNew[1:0] == 2'b00) && (pcNew[4:0] != 5'h14));

  // R2: base follows the high-vector select sampled one cycle earlier
  assert_vec_base_R2: assert property (@(posedge clk) disable iff (!rstN)
    spsrWrEn |-> ((pcNew & ~OFFS_MASK) == ($past(hiVecEn) ? HI_BASE : '0)));

  // R6: entry clears T and sets I
  assert_entry_bits_R6: assert property (@(posedge clk) disable iff (!rstN)
    spsrWrEn |-> psrWrEn && !psrNew[5] && psrNew[7]);

  // R7: saved status is the old status, all targets agree on the mode
  assert_spsr_copy_R7: assert property (@(posedge clk) disable iff (!rstN)
    spsrWrEn |-> (spsrVal == $past(curPsr)) && (spsrMode == psrNew[4:0]));

  // R8: link write accompanies entry, same mode
  assert_link_pair_R8: assert property (@(posedge clk) disable iff (!rstN)
    spsrWrEn |-> lrWrEn && pcLoad && (lrMode == spsrMode));

  // R9: return restores saved copy and link address
  assert_return_path_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && !spsrWrEn) |-> !lrWrEn && $past(retReq)
      && (psrNew == $past(savedPsr)) && (pcNew == $past(retLink)));

  // R10: strobes are single-cycle with a quiet cycle after
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> !pcLoad && !psrWrEn && !spsrWrEn && !lrWrEn);

  // R11: nothing is issued while in reset
  always_comb begin
    if (!rstN) begin
      assert_quiet_reset_R11: assert (!psrWrEn && !spsrWrEn && !lrWrEn && !pcLoad);
    end
  end

endmodule

bind exc_vec_unit exc_vec_checker #(.DATA_W(DATA_W), .HI_BASE(HI_BASE)) i_chk (.*);

// File: tb/test_exc_vec_unit.sv
module test_exc_vec_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] curPsr, curPc, savedPsr, retLink;
  logic        hiVecEn, reqReset, reqUndef, reqSwi, reqPabt, reqDabt, reqIrq, reqFiq, retReq;
  logic        psrWrEn, spsrWrEn, lrWrEn, pcLoad;
  logic [31:0] psrNew, spsrVal, lrVal, pcNew;
  logic [4:0]  spsrMode, lrMode;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_vec_unit i_exc_vec_unit (.*);

  // bench request order: 0 reset,1 dabt,2 fiq,3 irq,4 pabt,5 undef,6 swi
  logic        eTaken, eEntry;
  logic [31:0] ePsr, eSpsr, eLr, ePc;
  logic [4:0]  eMode;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] r, input logic ret);
    reqReset = r[0]; reqDabt = r[1]; reqFiq = r[2]; reqIrq = r[3];
    reqPabt  = r[4]; reqUndef = r[5]; reqSwi = r[6]; retReq = ret;
  endtask

  task automatic model(input logic [6:0] r, input logic ret);
    logic [6:0] eff;
    int k;
    logic [4:0] off;
    eff = r;
    if (curPsr[7]) eff[3] = 1'b0;
    if (curPsr[6]) eff[2] = 1'b0;
    eEntry = |eff;
    eTaken = eEntry || ret;
    k = 0;
    for (int i = 6; i >= 0; i--) if (eff[i]) k = i;
    case (k)
      0: begin eMode = 5'h13; off = 5'h00; end
      1: begin eMode = 5'h17; off = 5'h10; end
      2: begin eMode = 5'h11; off = 5'h1C; end
      3: begin eMode = 5'h12; off = 5'h18; end
      4: begin eMode = 5'h17; off = 5'h0C; end
      5: begin eMode = 5'h1B; off = 5'h04; end
      default: begin eMode = 5'h13; off = 5'h08; end
    endcase
    if (eEntry) begin
      ePsr = {curPsr[31:8], 1'b1, curPsr[6] | (k == 0) | (k == 2), 1'b0, eMode};
      eSpsr = curPsr;
      eLr = curPc + ((k == 1) ? 32'd8 : 32'd4);
      ePc = (hiVecEn ? 32'hFFFF_0000 : 32'h0) | {27'd0, off};
    end else begin
      ePsr = savedPsr;
      ePc  = retLink;
    end
  endtask

  // called at a negedge; leaves the bench at a negedge with the block idle
  task automatic txn(input logic [6:0] r, input logic ret, input string tag);
    drive(r, ret);
    model(r, ret);
    @(posedge clk); @(negedge clk);
    drive(7'h0, 1'b0);
    chk({tag, " R10 pcLoad"}, {31'd0, pcLoad}, {31'd0, eTaken});
    chk({tag, " R9 psrWrEn"}, {31'd0, psrWrEn}, {31'd0, eTaken});
    chk({tag, " R7 spsrWrEn"}, {31'd0, spsrWrEn}, {31'd0, eEntry});
    chk({tag, " R8 lrWrEn"}, {31'd0, lrWrEn}, {31'd0, eEntry});
    if (eTaken) begin
      chk({tag, " R1 pcNew"}, pcNew, ePc);
      chk({tag, " R6 psrNew"}, psrNew, ePsr);
    end
    if (eEntry) begin
      chk({tag, " R7 spsrVal"}, spsrVal, eSpsr);
      chk({tag, " R5 spsrMode"}, {27'd0, spsrMode}, {27'd0, eMode});
      chk({tag, " R8 lrVal"}, lrVal, eLr);
      chk({tag, " R8 lrMode"}, {27'd0, lrMode}, {27'd0, eMode});
    end
    if (eTaken) begin
      // settling cycle: a request here must be ignored
      drive(7'h03, 1'b1);
      @(posedge clk); @(negedge clk);
      drive(7'h0, 1'b0);
      chk({tag, " R10 quiet"}, {28'd0, pcLoad, psrWrEn, spsrWrEn, lrWrEn}, 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    rstN = 1'b0;
    curPsr = 32'h0000_0010; curPc = 32'h0000_8000;
    savedPsr = 32'h0; retLink = 32'h0; hiVecEn = 1'b0;
    drive(7'h0, 1'b0);
    repeat (2) @(negedge clk);
    drive(7'h7F, 1'b1);
    @(negedge clk);
    chk("R11 reset quiet", {28'd0, pcLoad, psrWrEn, spsrWrEn, lrWrEn}, 32'd0);
    drive(7'h0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // each kind alone, low vectors then high
    for (int b = 0; b < 2; b++) begin
      hiVecEn = b[0];
      for (int k = 0; k < 7; k++) begin
        curPsr = 32'hA000_0030; curPc = 32'h0000_1000 + 32'(k * 16);
        txn(7'(1 << k), 1'b0, b[0] ? "R2 single" : "R1 single");
      end
    end
    hiVecEn = 1'b0;
    // priority: all raised, then peel off the winner
    curPsr = 32'h0000_0010;
    txn(7'h7F, 1'b0, "R3 all");
    txn(7'h7E, 1'b0, "R3 no reset");
    txn(7'h7C, 1'b0, "R3 fiq wins");
    txn(7'h78, 1'b0, "R3 irq wins");
    txn(7'h70, 1'b0, "R3 pabt wins");
    txn(7'h60, 1'b0, "R3 undef wins");
    // masking
    curPsr = 32'h0000_00D3;
    txn(7'h0C, 1'b0, "R4 both masked");
    txn(7'h4C, 1'b0, "R4 masked over swi");
    curPsr = 32'h0000_0053;
    txn(7'h0C, 1'b0, "R4 fiq masked irq open");
    curPsr = 32'h0000_0093;
    txn(7'h0C, 1'b0, "R4 irq masked fiq open");
    // return
    savedPsr = 32'h6000_0030; retLink = 32'h0000_2468;
    txn(7'h00, 1'b1, "R9 return");
    curPsr = 32'h0000_0010;
    txn(7'h10, 1'b1, "R9 entry beats return");
    // link wrap
    curPc = 32'hFFFF_FFFC;
    txn(7'h02, 1'b0, "R8 wrap dabt");

    for (int n = 0; n < 400; n++) begin
      logic [6:0] r;
      for (int i = 0; i < 7; i++) r[i] = ($urandom % 5) == 0;
      curPsr = $urandom; curPc = $urandom; savedPsr = $urandom; retLink = $urandom;
      hiVecEn = $urandom % 2;
      txn(r, ($urandom % 3) == 0, "R6 random");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule